// File: doc/BRIEF.md
# Buffered SPI Master

This block is a full-duplex SPI master that sits behind a small register-style interface. Software writes a byte into a one-entry transmit holding register. The block moves that byte into its shifter as soon as the serial engine is idle. It then clocks the byte out on `mosi` while it clocks a byte in from `miso`. The received byte lands in a one-entry receive register. Software reads it and acknowledges it with `rd_en`.

Two flags carry the handshake. `txe` says the holding register can take a byte. `rxne` says a received byte is waiting. If a frame completes while the previous byte is still unread, the new byte replaces it and a sticky `ovr` flag records the loss. The serial clock polarity, the clock phase, the bit order and the half-period divider are plain configuration inputs. They must be held steady while `busy` is high. The chip-select line is a register that only software writes.

The serial engine is a three-state machine:
- `ST_IDLE`: SCK sits at its idle level. The machine leaves this state (transition *load*) when the holding register is full.
- `ST_LEAD`: the machine waits for the leading SCK edge of the current bit. It moves to `ST_TRAIL` on that edge (transition *leading edge*).
- `ST_TRAIL`: the machine waits for the trailing edge. On that edge it returns to `ST_LEAD` (transition *next bit*). After the eighth bit it returns to `ST_IDLE` instead (transition *frame end*).

Top module: `spi_buffered_master`

## Requirements
- R1: Every frame is full duplex. After a frame, `rd_data` holds the eight bits that were presented on `miso` at the eight sampling edges. They are assembled in the configured bit order, so the byte driven by the slave is returned unchanged.
- R2: With `cfg_lsb_first`=0, the bits of the written byte appear on `mosi` from bit 7 down to bit 0. With `cfg_lsb_first`=1, they appear from bit 0 up to bit 7.
- R3: While `busy` is low, `sck` equals `cfg_cpol` one cycle after the previous clock edge. So it idles low for `cfg_cpol`=0 and high for `cfg_cpol`=1.
- R4: With `cfg_cpha`=0, the first `mosi` bit is valid from the cycle after the load, before the first SCK edge. Data is sampled on leading edges and changed on trailing edges. With `cfg_cpha`=1, `mosi` changes on leading edges and is sampled on trailing edges. `mosi` never changes during a busy cycle in which `sck` does not change.
- R5: A frame has exactly eight SCK periods. Each half period lasts `cfg_half_div`+1 system clocks, so `busy` stays high for 16×(`cfg_half_div`+1) cycles.
- R6: `txe` is 1 after reset. A write while `txe`=1 clears it on the next edge. `txe` returns to 1 on the edge at which the byte is loaded into the shifter. That is the first edge at which the engine is idle and the register is full.
- R7: `rxne` rises on the final SCK edge of a frame, together with the new `rd_data`. A `rd_en` pulse clears it.
- R8: If a frame ends while `rxne` is 1 and `rd_en` is 0, `ovr` becomes 1 and stays 1 until a `stat_clr` pulse. The new byte still replaces `rd_data`.
- R9: `busy` rises on the load edge. It falls on the edge that returns SCK to its idle level after the last bit.
- R10: `cs_n` is 1 after reset. It takes `cs_wdata` on each edge where `cs_we`=1 and never changes otherwise, including across frames.
- R11: A write while `txe`=0 is ignored. The frame then in flight or pending still transmits the earlier byte, and no extra frame is started.
- R12: After reset, `txe`=1, `rxne`=0, `ovr`=0, `busy`=0, `sck`=0, `mosi`=0 and `cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: shift least significant bit first |
| cfg_half_div | input | DIV_W (8) | SCK half period minus one, in system clocks |
| wr_en | input | 1 | Write strobe for the transmit register |
| wr_data | input | FRAME_W (8) | Byte to transmit |
| rd_en | input | 1 | Read acknowledge, clears `rxne` |
| rd_data | output | FRAME_W (8) | Last received byte |
| stat_clr | input | 1 | Clears the overrun flag |
| cs_we | input | 1 | Write strobe for the chip-select register |
| cs_wdata | input | 1 | New chip-select level |
| txe | output | 1 | Transmit register can accept a byte |
| rxne | output | 1 | Received byte waiting |
| ovr | output | 1 | Sticky overrun flag |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| cs_n | output | 1 | Software-driven chip select |

## Verification
After a write, `txe` falls on the next edge and `busy` rises one edge later. The first SCK edge follows after `cfg_half_div`+1 further cycles. `rxne` and `rd_data` update on the edge that ends the sixteenth half period. A behavioural model in the bench advances on each rising edge using the same inputs and counts each of these delays itself. Every output is compared with the model at the falling edge, where all registers have settled. Frame-level checks (received byte, serialised byte, busy length) are taken one falling edge after `busy` drops. By then the bench's own slave-side capture has seen the last sampling edge.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    // Serial engine phases: idle, waiting for leading edge, waiting for trailing edge
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } phase_t;

endpackage

// File: rtl/spi_bm_tick.sv
module spi_bm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // One pulse every half+1 cycles while running; counter parked at zero otherwise
    assign tick = run && (cnt_q == half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
    import spi_bm_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               lsb_first,
    input  logic               start,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               tick,
    input  logic               miso,
    output logic               load,
    output logic               done,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sck,
    output logic               mosi,
    output logic               busy
);

    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    function automatic logic head(input logic [FRAME_W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[FRAME_W-1];
    endfunction

    function automatic logic [FRAME_W-1:0] advance(input logic [FRAME_W-1:0] v, input logic lsb);
        return lsb ? (v >> 1) : (v << 1);
    endfunction

    phase_t             state_q, state_d;
    logic [CNT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] tx_sr, rx_sr, rx_next;
    logic               sck_q, mosi_q;
    logic               lead_edge, trail_edge, last, sample, drive;

    assign lead_edge  = (state_q == ST_LEAD)  && tick;
    assign trail_edge = (state_q == ST_TRAIL) && tick;
    assign last       = (bit_q == LAST_BIT);
    assign load       = (state_q == ST_IDLE) && start;
    assign done       = trail_edge && last;
    assign sample     = cpha ? trail_edge : lead_edge;
    assign drive      = cpha ? lead_edge : (trail_edge && !last);

    // Received bit enters at the end that matches the chosen order
    always_comb begin
        rx_next = rx_sr;
        if (sample) begin
            if (lsb_first) begin
                rx_next = {miso, rx_sr[FRAME_W-1:1]};
            end else begin
                rx_next = {rx_sr[FRAME_W-2:0], miso};
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = last ? ST_IDLE : ST_LEAD;
            default:             state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                sck_q <= cpol;
            end else if (tick) begin
                sck_q <= ~sck_q;
            end

            if (load) begin
                bit_q <= '0;
                if (cpha) begin
                    tx_sr <= load_data;
                end else begin
                    mosi_q <= head(load_data, lsb_first);
                    tx_sr  <= advance(load_data, lsb_first);
                end
            end else if (drive) begin
                mosi_q <= head(tx_sr, lsb_first);
                tx_sr  <= advance(tx_sr, lsb_first);
            end

            rx_sr <= rx_next;

            if (trail_edge) begin
                bit_q <= bit_q + CNT_W'(1);
            end
        end
    end

    assign rx_data = rx_next;
    assign sck     = sck_q;
    assign mosi    = mosi_q;
    assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master #(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic               cfg_lsb_first,
    input  logic [DIV_W-1:0]   cfg_half_div,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               rd_en,
    output logic [FRAME_W-1:0] rd_data,
    input  logic               stat_clr,
    input  logic               cs_we,
    input  logic               cs_wdata,
    output logic               txe,
    output logic               rxne,
    output logic               ovr,
    output logic               busy,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_n
);

    logic [FRAME_W-1:0] tx_buf, rx_buf, rx_word;
    logic               txe_q, rxne_q, ovr_q, cs_q;
    logic               tick, load, done, busy_w;

    spi_bm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .half  (cfg_half_div),
        .tick  (tick)
    );

    spi_bm_engine #(.FRAME_W(FRAME_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .lsb_first (cfg_lsb_first),
        .start     (!txe_q),
        .load_data (tx_buf),
        .tick      (tick),
        .miso      (miso),
        .load      (load),
        .done      (done),
        .rx_data   (rx_word),
        .sck       (sck),
        .mosi      (mosi),
        .busy      (busy_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf <= '0;
            txe_q  <= 1'b1;
            rx_buf <= '0;
            rxne_q <= 1'b0;
            ovr_q  <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            // Load and accepted write are exclusive: load needs txe low, write needs it high
            if (load) begin
                txe_q <= 1'b1;
            end else if (wr_en && txe_q) begin
                tx_buf <= wr_data;
                txe_q  <= 1'b0;
            end

            if (done && rxne_q && !rd_en) begin
                ovr_q <= 1'b1;
            end else if (stat_clr) begin
                ovr_q <= 1'b0;
            end

            if (done) begin
                rx_buf <= rx_word;
                rxne_q <= 1'b1;
            end else if (rd_en) begin
                rxne_q <= 1'b0;
            end

            if (cs_we) begin
                cs_q <= cs_wdata;
            end
        end
    end

    assign rd_data = rx_buf;
    assign txe     = txe_q;
    assign rxne    = rxne_q;
    assign ovr     = ovr_q;
    assign busy    = busy_w;
    assign cs_n    = cs_q;

endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic wr_en,
    input logic stat_clr,
    input logic cs_we,
    input logic txe,
    input logic rxne,
    input logic ovr,
    input logic busy,
    input logic sck,
    input logic mosi,
    input logic cs_n
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !busy && $past(!busy)) |-> (sck == $past(cfg_cpol)));

    a_r4_mosi_only_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && busy && $past(busy) && $stable(sck)) |-> $stable(mosi));

    a_r6_write_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && txe) |=> !txe);

    a_r9_load_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> txe);

    a_r7_frame_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rxne);

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !stat_clr) |=> ovr);

    a_r10_cs_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_we |=> $stable(cs_n));

endmodule

bind spi_buffered_master spi_bm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .wr_en    (wr_en),
    .stat_clr (stat_clr),
    .cs_we    (cs_we),
    .txe      (txe),
    .rxne     (rxne),
    .ovr      (ovr),
    .busy     (busy),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n)
);

// File: tb/sim_spi_buffered_master.sv
module sim_spi_buffered_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
    logic [7:0] cfg_half = 8'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0, stat_clr = 1'b0, cs_we = 1'b0, cs_wdata = 1'b1;
    logic [7:0] wr_data = 8'd0;
    logic       miso = 1'b1;
    logic [7:0] rd_data;
    logic       txe, rxne, ovr, busy, sck, mosi, cs_n;

    int  n_vec = 0;
    int  n_fail = 0;
    bit  chk_on = 0;
    logic [7:0] slave_byte = 8'h00;

    always #2 clk = ~clk;

    spi_buffered_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb), .cfg_half_div(cfg_half), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .stat_clr(stat_clr),
        .cs_we(cs_we), .cs_wdata(cs_wdata), .txe(txe), .rxne(rxne), .ovr(ovr),
        .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic int ord(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    // ---------------- behavioural reference model ----------------
    bit m_txe, m_rxne, m_ovr, m_busy, m_sck, m_mosi, m_cs;
    bit m_fin, m_load, m_old_txe, m_lead;
    logic [7:0] m_txbuf, m_frame, m_rx, m_rdata;
    int m_cnt, m_edge;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txe = 1; m_rxne = 0; m_ovr = 0; m_busy = 0; m_sck = 0; m_mosi = 0; m_cs = 1;
            m_txbuf = 0; m_frame = 0; m_rx = 0; m_rdata = 0; m_cnt = 0; m_edge = 0;
        end else begin
            m_fin = 0; m_load = 0; m_old_txe = m_txe;
            if (m_busy) begin
                if (m_cnt == int'(cfg_half)) begin
                    m_cnt = 0;
                    m_sck = ~m_sck;
                    m_lead = (m_edge % 2 == 0);
                    if (!cfg_cpha) begin
                        if (m_lead) m_rx[ord(m_edge / 2, cfg_lsb)] = miso;
                        else if (m_edge < 15) m_mosi = m_frame[ord(m_edge / 2 + 1, cfg_lsb)];
                    end else begin
                        if (m_lead) m_mosi = m_frame[ord(m_edge / 2, cfg_lsb)];
                        else m_rx[ord(m_edge / 2, cfg_lsb)] = miso;
                    end
                    if (m_edge == 15) m_fin = 1;
                    m_edge++;
                end else begin
                    m_cnt++;
                end
            end else begin
                m_sck = cfg_cpol;
                if (!m_txe) begin
                    m_load = 1; m_busy = 1; m_cnt = 0; m_edge = 0; m_frame = m_txbuf;
                    if (!cfg_cpha) m_mosi = m_frame[ord(0, cfg_lsb)];
                end
            end
            if (m_load) m_txe = 1;
            else if (wr_en && m_old_txe) begin m_txbuf = wr_data; m_txe = 0; end
            if (m_fin && m_rxne && !rd_en) m_ovr = 1;
            else if (stat_clr) m_ovr = 0;
            if (m_fin) begin m_rxne = 1; m_rdata = m_rx; m_busy = 0; end
            else if (rd_en) m_rxne = 0;
            if (cs_we) m_cs = cs_wdata;
        end
    end

    // slave: presents the next bit of slave_byte ahead of each sampling edge
    always @(negedge clk) begin
        miso = m_busy ? slave_byte[ord(m_edge / 2, cfg_lsb)] : 1'b1;
    end

    // slave-side capture of mosi at sampling edges, and busy length
    logic [7:0] cap = 8'h00;
    int capn = 0;
    int busy_len = 0;
    logic prev_sck = 1'b0, prev_busy = 1'b0;
    always @(negedge clk) begin
        if (busy && !prev_busy) begin capn = 0; busy_len = 1; end
        else if (busy) busy_len++;
        if (sck != prev_sck && capn < 8 &&
            (cfg_cpha ? (sck == cfg_cpol) : (sck != cfg_cpol))) begin
            cap[ord(capn, cfg_lsb)] = mosi;
            capn++;
        end
        prev_sck = sck;
        prev_busy = busy;
    end

    task automatic cmp1(input logic act, input logic exp, input string tag);
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            n_vec++;
            cmp1(txe, m_txe, "R6 txe");
            cmp1(rxne, m_rxne, "R7 rxne");
            cmp1(ovr, m_ovr, "R8 ovr");
            cmp1(busy, m_busy, "R9 busy");
            cmp1(sck, m_sck, m_busy ? "R4 sck" : "R3 sck");
            cmp1(mosi, m_mosi, "R2 mosi");
            cmp1(cs_n, m_cs, "R10 cs_n");
            if (rd_data !== m_rdata) begin
                n_fail++;
                $display("FAIL R1 rd_data actual=%02h expected=%02h at %0t", rd_data, m_rdata, $time);
            end
        end
    end

    task automatic check_eq(input int act, input int exp, input string tag);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    task automatic wait_busy(input logic lvl);
        int t = 0;
        while (busy !== lvl && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) begin
            n_fail++;
            $display("FAIL R9 watchdog actual busy=%0b expected=%0b", busy, lvl);
        end
    endtask

    task automatic set_mode(input logic pol, input logic pha, input logic lsb, input int half);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb = lsb; cfg_half = 8'(half);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic write_cs(input logic v);
        @(negedge clk); cs_we = 1'b1; cs_wdata = v;
        @(negedge clk); cs_we = 1'b0;
    endtask

    // one complete frame with frame-level checks
    task automatic frame(input logic [7:0] d, input logic [7:0] s, input bit do_read);
        slave_byte = s;
        write_byte(d);
        wait_busy(1'b1);
        if (!cfg_cpha) check_eq(int'(mosi), int'(d[ord(0, cfg_lsb)]), "R4 first bit before first edge");
        wait_busy(1'b0);
        @(negedge clk);
        check_eq(int'(rd_data), int'(s), "R1 received byte");
        check_eq(int'(cap), int'(d), "R2 serialised byte");
        check_eq(busy_len, 16 * (int'(cfg_half) + 1), "R5 busy length");
        check_eq(int'(sck), int'(cfg_cpol), "R3 idle level");
        check_eq(int'(rxne), 1, "R7 rxne set");
        if (do_read) begin
            pulse_rd();
            @(negedge clk);
            check_eq(int'(rxne), 0, "R7 rxne cleared");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 global watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check_eq(int'(txe), 1, "R12 txe");
        check_eq(int'(rxne), 0, "R12 rxne");
        check_eq(int'(ovr), 0, "R12 ovr");
        check_eq(int'(busy), 0, "R12 busy");
        check_eq(int'(sck), 0, "R12 sck");
        check_eq(int'(mosi), 0, "R12 mosi");
        check_eq(int'(cs_n), 1, "R12 cs_n");
        rst_n = 1'b1;
        chk_on = 1;

        write_cs(1'b0);
        @(negedge clk);
        check_eq(int'(cs_n), 0, "R10 cs low");

        set_mode(0, 0, 0, 1); frame(8'h3C, 8'hA5, 1);
        set_mode(0, 1, 1, 0); frame(8'h1E, 8'h6B, 1);
        set_mode(1, 0, 0, 2); frame(8'hD2, 8'h37, 1);
        repeat (4) @(negedge clk);
        check_eq(int'(sck), 1, "R3 idle high");
        set_mode(1, 1, 1, 3); frame(8'h47, 8'hE8, 1);

        // R8 overrun
        set_mode(0, 0, 0, 0);
        frame(8'h55, 8'h0F, 0);
        frame(8'hAA, 8'hF0, 0);
        check_eq(int'(ovr), 1, "R8 overrun set");
        check_eq(int'(rd_data), 8'hF0, "R8 newest byte kept");
        pulse_clr();
        @(negedge clk);
        check_eq(int'(ovr), 0, "R8 overrun cleared");
        pulse_rd();

        // R11 write while txe low is ignored
        slave_byte = 8'h99;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h6D;
        @(negedge clk); wr_data = 8'hB4;
        @(negedge clk); wr_en = 1'b0;
        wait_busy(1'b1);
        wait_busy(1'b0);
        @(negedge clk);
        check_eq(int'(cap), 8'h6D, "R11 first byte sent");
        repeat (10) @(negedge clk);
        check_eq(int'(busy), 0, "R11 no extra frame");
        check_eq(int'(txe), 1, "R11 txe stays set");
        pulse_rd();

        // R6 back-to-back: second byte buffered while busy
        set_mode(0, 0, 1, 1);
        slave_byte = 8'h2C;
        write_byte(8'hC1);
        wait_busy(1'b1);
        write_byte(8'h7E);
        check_eq(int'(txe), 0, "R6 held while busy");
        wait_busy(1'b0);
        check_eq(int'(cap), 8'hC1, "R6 first of pair");
        wait_busy(1'b1);
        wait_busy(1'b0);
        @(negedge clk);
        check_eq(int'(cap), 8'h7E, "R6 second of pair");
        check_eq(int'(ovr), 1, "R8 unread pair overrun");
        pulse_clr();
        pulse_rd();

        write_cs(1'b1);
        @(negedge clk);
        check_eq(int'(cs_n), 1, "R10 cs high");
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule